// File: doc/BRIEF.md
# Watchdog Timer with Prescaler and Status Flags

This block is a watchdog that keeps counting unless software restarts it. Each enabled cycle advances a prescaler. The prescaler divides the clock by a power of two chosen through a 3-bit ratio select. Each prescaler tick advances an 8-bit main counter. When the main counter rolls over from its top value, the block raises a one-cycle time-out pulse for the system reset logic. It also drops the time-out status flag so that software can later see why the reset happened.

Two single-cycle strobes act on the block. The clear strobe stands for the software "kick the watchdog" instruction. It zeroes the main counter and the prescaler, and it sets both the time-out flag and the power-down flag to 1. The sleep strobe stands for entry into low-power mode. It also zeroes the counter and the prescaler, but it drops the power-down flag and leaves the time-out flag as it was. While the enable is low, the count stays at zero and no time-out can occur.

Top module: `wdog_timer`

## Requirements
- R1: After a synchronous active-low reset, the time-out flag and the power-down flag both read 1 and the time-out pulse is low.
- R2: A ratio select value s (0 to 7) makes the main counter advance once every 2^s enabled cycles. With no strobes, a time-out therefore comes 256·2^s cycles after a restart.
- R3: A time-out leaves the count at zero and counting goes on. The next time-out follows a full period later with no strobe in between.
- R4: The time-out pulse and the clearing of the time-out flag to 0 happen on the same clock edge.
- R5: The clear strobe zeroes both the main counter and the prescaler. A clear issued partway through a count starts a full new period.
- R6: The clear strobe sets both the time-out flag and the power-down flag to 1 on the next edge.
- R7: The sleep strobe (without clear) drops the power-down flag to 0, leaves the time-out flag unchanged, and restarts the counter and the prescaler.
- R8: When clear and sleep arrive in the same cycle, clear takes priority: both flags read 1 afterwards.
- R9: While the enable is low, the counter and the prescaler hold at zero and no time-out occurs. After the enable returns, a full period passes before the next time-out.
- R10: The time-out pulse is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Software clear strobe |
| sleep_i | input | 1 | Sleep-entry strobe |
| en_i | input | 1 | Watchdog enable |
| ratio_sel_i | input | 3 | Prescaler ratio select, ratio 1:2^value |
| timeout_o | output | 1 | One-cycle time-out reset pulse |
| to_flag_o | output | 1 | Time-out status flag (0 after a time-out) |
| pd_flag_o | output | 1 | Power-down status flag (0 after sleep) |

## Verification
The period is measured with ratio selects of 0, 3 and 7. This separates a prescaler that ignores the select, or divides by the wrong power, from a correct one. Free-running back-to-back time-outs are compared with clears and sleeps issued partway through a count. That shows whether each restart really zeroes both the counter and the prescaler, rather than letting a stale prescaler phase carry over. Sleep is issued while the time-out flag is 0, and clear and sleep are issued together. These show whether each strobe updates only its own flags and whether clear wins. A long stretch with the enable low tells a held counter apart from one that keeps running quietly.

// File: rtl/wdog_pkg.sv
// Package: shared command encoding for the watchdog sub-blocks.
// Assumes the strobes are synchronous to the watchdog clock.
package wdog_pkg;

    // Decoded per-cycle action; clear outranks sleep, sleep outranks disable.
    typedef enum logic [1:0] {
        WCMD_RUN   = 2'd0,
        WCMD_CLEAR = 2'd1,
        WCMD_SLEEP = 2'd2,
        WCMD_HOLD  = 2'd3
    } wcmd_e;

    // Turn the raw inputs into one action with fixed priority.
    function automatic wcmd_e wcmd_decode(input logic clr, input logic sleep, input logic en);
        if (clr)        return WCMD_CLEAR;
        else if (sleep) return WCMD_SLEEP;
        else if (!en)   return WCMD_HOLD;
        else            return WCMD_RUN;
    endfunction

endpackage

// File: rtl/wdog_prescaler.sv
// Module: power-of-two prescaler. It raises tick once every 2^sel cycles while run is high.
// Assumes run low means "restart": the prescale count goes back to zero.
module wdog_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;

    // Terminal count for the selected ratio: 2^sel - 1.
    always_comb lim = {PRE_W{1'b1}} >> (PRE_W - int'(sel));

    // Tick once the count reaches or passes the terminal value.
    always_comb tick = run && (pre_q >= lim);

    // Advance the prescale count, or zero it on restart or tick.
    always_ff @(posedge clk) begin
        if (!rst_n)     pre_q <= '0;
        else if (!run)  pre_q <= '0;
        else if (tick)  pre_q <= '0;
        else            pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/wdog_counter.sv
// Module: main watchdog counter. It advances on each prescaler tick and flags the roll-over.
// Assumes tick is only high while run is high.
module wdog_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf
);
    // Roll-over: a tick while the count is at its top value.
    always_comb ovf = tick && (cnt_q == {CNT_W{1'b1}});

    // Count ticks; a restart forces zero and the roll-over wraps to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (!run)  cnt_q <= '0;
        else if (tick)  cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/wdog_flags.sv
// Module: time-out pulse register and the time-out / power-down status flags.
// Assumes ovf can only be high when the decoded action is RUN.
module wdog_flags
    import wdog_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  wcmd_e cmd,
    input  logic  ovf,
    output logic  timeout_q,
    output logic  to_q,
    output logic  pd_q
);
    // Register the roll-over as a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) timeout_q <= 1'b0;
        else        timeout_q <= ovf;
    end

    // Time-out flag: set by clear, dropped by roll-over.
    always_ff @(posedge clk) begin
        if (!rst_n)                 to_q <= 1'b1;
        else if (cmd == WCMD_CLEAR) to_q <= 1'b1;
        else if (ovf)               to_q <= 1'b0;
    end

    // Power-down flag: set by clear, dropped by sleep.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pd_q <= 1'b1;
        else if (cmd == WCMD_CLEAR) pd_q <= 1'b1;
        else if (cmd == WCMD_SLEEP) pd_q <= 1'b0;
    end
endmodule

// File: rtl/wdog_timer.sv
// Module: watchdog top. Prescaler, then main counter, then status flags.
// Assumes clr_i and sleep_i are single-cycle strobes in the clk domain.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             sleep_i,
    input  logic             en_i,
    input  logic [SEL_W-1:0] ratio_sel_i,
    output logic             timeout_o,
    output logic             to_flag_o,
    output logic             pd_flag_o
);
    wcmd_e            cmd;
    logic             run;
    logic             tick;
    logic             ovf;
    logic [CNT_W-1:0] cnt_q;

    // Decode this cycle's action and whether counting proceeds.
    always_comb begin
        cmd = wcmd_decode(clr_i, sleep_i, en_i);
        run = (cmd == WCMD_RUN);
    end

    wdog_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .sel(ratio_sel_i), .tick(tick)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .cnt_q(cnt_q), .ovf(ovf)
    );

    wdog_flags u_flg (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .ovf(ovf),
        .timeout_q(timeout_o), .to_q(to_flag_o), .pd_q(pd_flag_o)
    );
endmodule

// File: rtl/wdog_timer_chk.sv
// Module: assertion checker bound to wdog_timer; observes ports and the main count.
module wdog_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_i,
    input logic             sleep_i,
    input logic             en_i,
    input logic             timeout_o,
    input logic             to_flag_o,
    input logic             pd_flag_o,
    input logic [CNT_W-1:0] cnt
);
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o);

    a_r4_pulse_drops_to: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> !to_flag_o);

    a_r6_clr_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (to_flag_o && pd_flag_o));

    a_r5_clr_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt == '0));

    a_r7_sleep_drops_pd: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && !clr_i) |=> !pd_flag_o);

    a_r7_sleep_keeps_to: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && !clr_i) |=> (to_flag_o == $past(to_flag_o)));

    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!timeout_o && cnt == '0));
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .sleep_i(sleep_i), .en_i(en_i),
    .timeout_o(timeout_o), .to_flag_o(to_flag_o), .pd_flag_o(pd_flag_o), .cnt(cnt_q)
);

// File: tb/tb_wdog_timer.sv
// Bench: a behavioural reference model runs beside the DUT and is compared every
// cycle; directed tests measure periods and check flags. Inputs change on negedge.
module tb_wdog_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_i = 1'b0;
    logic       sleep_i = 1'b0;
    logic       en_i = 1'b1;
    logic [2:0] ratio_sel_i = 3'd0;
    logic       timeout_o, to_flag_o, pd_flag_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // Reference model state.
    int m_pre = 0, m_cnt = 0;
    bit m_tmo = 0, m_to = 1, m_pd = 1;

    always #4 clk = ~clk;

    wdog_timer dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .sleep_i(sleep_i), .en_i(en_i),
        .ratio_sel_i(ratio_sel_i), .timeout_o(timeout_o),
        .to_flag_o(to_flag_o), .pd_flag_o(pd_flag_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model: updated on each rising edge from the requirements.
    always @(posedge clk) begin
        m_tmo = 0;
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_to = 1; m_pd = 1;
        end else if (clr_i) begin
            m_pre = 0; m_cnt = 0; m_to = 1; m_pd = 1;
        end else begin
            if (sleep_i) m_pd = 0;
            if (sleep_i || !en_i) begin
                m_pre = 0; m_cnt = 0;
            end else if (m_pre + 1 >= (1 << ratio_sel_i)) begin
                m_pre = 0;
                if (m_cnt == 255) begin m_cnt = 0; m_tmo = 1; m_to = 0; end
                else m_cnt++;
            end else m_pre++;
        end
    end

    // Compare against the model every cycle, plus a watchdog on the run.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 1) begin
            check(timeout_o == m_tmo, "R3 model timeout", timeout_o, m_tmo);
            check(to_flag_o == m_to,  "R4 model TO",      to_flag_o, m_to);
            check(pd_flag_o == m_pd,  "R7 model PD",      pd_flag_o, m_pd);
        end
        if (cyc > 190000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <190000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic pulse_clr();
        @(negedge clk) clr_i = 1'b1;
        @(negedge clk) clr_i = 1'b0;
    endtask

    task automatic pulse_sleep();
        @(negedge clk) sleep_i = 1'b1;
        @(negedge clk) sleep_i = 1'b0;
    endtask

    // Count negedges until the time-out pulse is seen.
    task automatic measure(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!timeout_o && n < 40000);
    endtask

    initial begin
        int p;
        bit seen;
        repeat (3) @(negedge clk);
        check(to_flag_o == 1'b1, "R1 reset TO", to_flag_o, 1);
        check(pd_flag_o == 1'b1, "R1 reset PD", pd_flag_o, 1);
        check(timeout_o == 1'b0, "R1 reset pulse", timeout_o, 0);
        rst_n = 1'b1;

        // Ratio 1:1 period; flag and pulse width at the time-out.
        pulse_clr();
        measure(p);
        check(p == 256, "R2 period sel0", p, 256);
        check(to_flag_o == 1'b0, "R4 TO dropped with pulse", to_flag_o, 0);
        @(negedge clk);
        check(timeout_o == 1'b0, "R10 pulse one cycle", timeout_o, 0);
        measure(p);
        check(p == 255, "R3 free-running period", p + 1, 256);

        // Clear sets both flags.
        pulse_clr();
        check(to_flag_o && pd_flag_o, "R6 clear sets flags", {to_flag_o, pd_flag_o}, 3);

        // Larger ratios.
        ratio_sel_i = 3'd3;
        pulse_clr();
        measure(p);
        check(p == 2048, "R2 period sel3", p, 2048);
        ratio_sel_i = 3'd7;
        pulse_clr();
        measure(p);
        check(p == 32768, "R2 period sel7", p, 32768);

        // Clear partway through a count with the prescaler mid-phase.
        ratio_sel_i = 3'd2;
        pulse_clr();
        repeat (501) @(negedge clk);
        pulse_clr();
        measure(p);
        check(p == 1024, "R5 clear restarts period", p, 1024);

        // Sleep while TO is 0: PD drops, TO stays, count restarts.
        ratio_sel_i = 3'd0;
        repeat (100) @(negedge clk);
        pulse_sleep();
        check(pd_flag_o == 1'b0, "R7 sleep drops PD", pd_flag_o, 0);
        check(to_flag_o == 1'b0, "R7 sleep keeps TO", to_flag_o, 0);
        measure(p);
        check(p == 256, "R7 sleep restarts count", p, 256);

        // Clear and sleep together: clear wins.
        @(negedge clk) begin clr_i = 1'b1; sleep_i = 1'b1; end
        @(negedge clk) begin clr_i = 1'b0; sleep_i = 1'b0; end
        check(pd_flag_o == 1'b1, "R8 clear beats sleep PD", pd_flag_o, 1);
        check(to_flag_o == 1'b1, "R8 clear beats sleep TO", to_flag_o, 1);

        // Enable low for longer than a period: no time-out, then a full period.
        repeat (150) @(negedge clk);
        en_i = 1'b0;
        seen = 0;
        repeat (1000) begin
            @(negedge clk);
            if (timeout_o) seen = 1;
        end
        check(!seen, "R9 no time-out while disabled", seen, 0);
        en_i = 1'b1;
        measure(p);
        check(p == 256, "R9 full period after enable", p, 256);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule